// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register Window

This block puts a byte-wide static RAM and a small set of timekeeping registers behind one memory-mapped bus. The bus has an address, active-low chip, output and write enables, and a bidirectional data byte. The eight highest addresses hold clock registers. Every lower address is ordinary RAM.

An external calendar counter keeps running and supplies its current BCD time on `live_i`. The user-visible registers are a shadow copy of that time. The shadow reloads as a whole, in one clock cycle, on each one-second tick. Setting a halt bit in the control/century byte freezes the shadow, so software reads a consistent snapshot. The counter keeps running during the halt. When the halt bit is cleared, the next tick reloads the whole shadow.

A power-good input deselects the bus while it is low. The calendar arithmetic, supply sensing and battery switching are outside this block.

Top module: `rtc_window_top`

## Requirements
- R1: Addresses whose upper bits (all above bit 2) are all ones select the register set. The low three bits pick the register: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. All other addresses act as RAM, and a read returns the last byte written there.
- R2: `data_io` is driven only while `ce_ni` and `oe_ni` are low, `we_ni` is high and `pwr_ok_i` is high. Otherwise it is high impedance.
- R3: A write takes place on a rising clock edge where `ce_ni` and `we_ni` are both low and `pwr_ok_i` is high, and it stores the byte on `data_io`.
- R4: `live_i` carries byte k in bits 8k+7..8k, where k is the register offset. In byte 0 only bits 5..0 (the BCD century) are used. The control byte reads back as bit 7 = 0, bit 6 = halt, and bits 5..0 = century. Register offsets 1 to 7 read the shadow copy of the matching live byte.
- R5: While halt is 0, every cycle with `tick_i` high reloads all eight shadow bytes from `live_i` at that edge. Changes on `live_i` between ticks are not visible.
- R6: Writing 1 to bit 6 of the control byte while halt is 0 sets halt and captures `live_i` into the shadow at that same edge.
- R7: While halt is 1, the shadow does not change on ticks or on further writes of 1 to the halt bit.
- R8: After halt is written to 0, the shadow keeps its snapshot until the next tick, and that tick reloads all of it.
- R9: Writes to offsets 1 to 7 are ignored. A write to offset 0 changes only the halt bit.
- R10: While `pwr_ok_i` is low, writes to RAM and to the halt bit have no effect, and reads do not drive the bus.
- R11: After reset, halt is 0 and all shadow bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| data_io | inout | 8 | Bidirectional data byte |
| pwr_ok_i | input | 1 | Supply in tolerance |
| tick_i | input | 1 | One-second tick from the counter |
| live_i | input | 64 | Running BCD time from the counter, byte per offset |

## Verification
The bench changes `live_i` between ticks and while halted. A shadow that tracks the counter directly would expose the new values, when it should still hold the old ones. It writes the halt bit twice in a row. A design that captures on every write, instead of only on the 0-to-1 change, would replace the snapshot. After the halt is released it reads before the next tick, which catches a design that reloads at once. It also writes to the time registers and to the spare control bits to confirm they are dropped. With power low it tries a RAM write, a halt write and a read, and then checks that the RAM byte and the tick behaviour are unchanged.

// File: rtl/rtc_window_pkg.sv
package rtc_window_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned REG_CNT  = 8;
  localparam int unsigned OFF_W    = $clog2(REG_CNT);
  localparam int unsigned HALT_BIT = 6;
  localparam logic [DATA_W-1:0] CENT_MASK = 8'h3F;

  typedef enum logic [OFF_W-1:0] {
    OFF_CTRL  = 3'd0,
    OFF_SEC   = 3'd1,
    OFF_MIN   = 3'd2,
    OFF_HOUR  = 3'd3,
    OFF_DAY   = 3'd4,
    OFF_DATE  = 3'd5,
    OFF_MONTH = 3'd6,
    OFF_YEAR  = 3'd7
  } reg_off_e;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              pwr_ok_i,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              reg_sel_o,
  output reg_off_e          reg_off_o
);
  localparam int unsigned HI_W = ADDR_W - OFF_W;

  // power-fail deselect gates both directions
  assign rd_en_o   = pwr_ok_i && !ce_ni && !oe_ni && we_ni;
  assign wr_en_o   = pwr_ok_i && !ce_ni && !we_ni;
  assign reg_sel_o = &addr_i[ADDR_W-1:OFF_W];
  assign reg_off_o = reg_off_e'(addr_i[OFF_W-1:0]);

  initial begin
    a_r1_addr_fits : assert (HI_W > 0);
  end
endmodule

// File: rtl/rtc_sram.sv
module rtc_sram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_window_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic [REG_CNT*DATA_W-1:0] live_i,
  input  logic                      ctrl_wr_i,
  input  logic                      halt_wdata_i,
  input  reg_off_e                  reg_off_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      halt_o
);
  logic                             halt_q;
  logic                             capture;
  logic [REG_CNT-1:0][DATA_W-1:0]   user_q;
  logic [REG_CNT-1:0][DATA_W-1:0]   live_bytes;

  assign live_bytes = live_i;

  // snapshot only on the 0->1 edge of halt, or on a tick while running
  assign capture = !halt_q && (tick_i || (ctrl_wr_i && halt_wdata_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        halt_q <= 1'b0;
    else if (ctrl_wr_i) halt_q <= halt_wdata_i;
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_byte
    logic [DATA_W-1:0] load_val;
    if (g == 0) begin : g_cent
      assign load_val = live_bytes[g] & CENT_MASK;
    end else begin : g_time
      assign load_val = live_bytes[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      user_q[g] <= '0;
      else if (capture) user_q[g] <= load_val;
    end
  end

  always_comb begin
    if (reg_off_i == OFF_CTRL)
      rdata_o = (user_q[0] & ~(DATA_W'(1) << HALT_BIT)) | (DATA_W'(halt_q) << HALT_BIT);
    else
      rdata_o = user_q[reg_off_i];
  end

  assign halt_o = halt_q;

  // R7: while halted the snapshot is frozen
  a_r7_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(halt_q) |-> $stable(user_q));
  // R6: entering halt captures the live time of that edge
  a_r6_snapshot : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_q) |-> (user_q[1] == $past(live_bytes[1]) && user_q[7] == $past(live_bytes[7])));
  // R5: a tick while running reloads the copy
  a_r5_tick_load : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !halt_q) |=> (user_q[3] == $past(live_bytes[3])));
endmodule

// File: rtl/rtc_window_top.sv
module rtc_window_top
  import rtc_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      ce_ni,
  input  logic                      oe_ni,
  input  logic                      we_ni,
  inout  wire  [DATA_W-1:0]         data_io,
  input  logic                      pwr_ok_i,
  input  logic                      tick_i,
  input  logic [REG_CNT*DATA_W-1:0] live_i
);
  logic              rd_en, wr_en, reg_sel;
  reg_off_e          reg_off;
  logic [DATA_W-1:0] ram_rdata, reg_rdata, rd_data;
  logic              halt;

  rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .pwr_ok_i (pwr_ok_i),
    .rd_en_o  (rd_en),
    .wr_en_o  (wr_en),
    .reg_sel_o(reg_sel),
    .reg_off_o(reg_off)
  );

  rtc_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .wr_en_i(wr_en && !reg_sel),
    .addr_i (addr_i),
    .wdata_i(data_io),
    .rdata_o(ram_rdata)
  );

  rtc_shadow u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .live_i      (live_i),
    .ctrl_wr_i   (wr_en && reg_sel && reg_off == OFF_CTRL),
    .halt_wdata_i(data_io[HALT_BIT]),
    .reg_off_i   (reg_off),
    .rdata_o     (reg_rdata),
    .halt_o      (halt)
  );

  assign rd_data = reg_sel ? reg_rdata : ram_rdata;
  assign data_io = rd_en ? rd_data : 'z;

  // R10: no halt change while supply is out of tolerance
  a_r10_pwr_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> $stable(halt));
endmodule

// File: tb/rtc_window_tb.sv
module rtc_window_top_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] REG_BASE = {ADDR_W{1'b1}} - 7;

  logic              clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ce_n = 1, oe_n = 1, we_n = 1, pwr_ok = 1, tick = 0;
  logic [63:0]       live = '0;
  logic [7:0]        drv = '0;
  logic              drv_en = 0;
  wire  [7:0]        data_io;
  int vectors = 0, fails = 0;
  bit done = 0;

  assign data_io = drv_en ? drv : 'z;
  always #(CLK_P/2) clk = ~clk;

  rtc_window_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .data_io(data_io), .pwr_ok_i(pwr_ok), .tick_i(tick), .live_i(live)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; drv = d; drv_en = 1; ce_n = 0; we_n = 0;
    @(negedge clk); ce_n = 1; we_n = 1; drv_en = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] q);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; #1; q = data_io;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic logic [7:0] ctrl_exp(input logic h, input logic [63:0] l);
    return {1'b0, h, l[5:0]};
  endfunction

  task automatic check_all(input string req, input logic h, input logic [63:0] l);
    logic [7:0] q;
    rd(REG_BASE, q); chk(req, q, ctrl_exp(h, l));
    for (int k = 1; k < 8; k++) begin
      rd(REG_BASE + ADDR_W'(k), q); chk(req, q, l[8*k +: 8]);
    end
  endtask

  task automatic t_reset();
    check_all("R11 reset", 1'b0, 64'h0);
  endtask

  task automatic t_ram();
    logic [7:0] q;
    wr(10'h055, 8'hA5); wr(10'h000, 8'h3C); wr(REG_BASE - 1, 8'h77);
    rd(10'h055, q); chk("R1 R3 ram", q, 8'hA5);
    rd(10'h000, q); chk("R1 R3 ram", q, 8'h3C);
    rd(REG_BASE - 1, q); chk("R1 ram below regs", q, 8'h77);
    @(negedge clk); addr = 10'h055; ce_n = 1; oe_n = 0; #1;
    chk("R2 ce high z", data_io, 8'hzz);
    ce_n = 0; oe_n = 1; #1;
    chk("R2 oe high z", data_io, 8'hzz);
    ce_n = 1;
  endtask

  task automatic t_tick();
    logic [7:0] q;
    live = 64'h24_12_31_07_23_59_58_FA;
    rd(REG_BASE + 1, q); chk("R5 stale before tick", q, 8'h00);
    pulse_tick();
    check_all("R5 R4 tick load", 1'b0, live);
    live = 64'h24_12_31_07_23_59_59_20;
    rd(REG_BASE + 1, q); chk("R5 no update between ticks", q, 8'h58);
  endtask

  task automatic t_halt();
    logic [63:0] snap;
    live = 64'h25_01_01_03_00_00_00_20;
    snap = live;
    wr(REG_BASE, 8'h40);
    live = 64'h25_01_01_03_00_00_05_20;
    check_all("R6 capture on halt", 1'b1, snap);
    pulse_tick();
    check_all("R7 tick ignored", 1'b1, snap);
    wr(REG_BASE, 8'h40);
    check_all("R7 rewrite no recapture", 1'b1, snap);
    wr(REG_BASE, 8'h00);
    check_all("R8 hold until tick", 1'b0, snap);
    pulse_tick();
    check_all("R8 reload on tick", 1'b0, live);
  endtask

  task automatic t_ignored();
    logic [7:0] q;
    wr(REG_BASE + 1, 8'h99); wr(REG_BASE + 7, 8'h11);
    rd(REG_BASE + 1, q); chk("R9 sec write ignored", q, 8'h05);
    rd(REG_BASE + 7, q); chk("R9 year write ignored", q, 8'h25);
    wr(REG_BASE, 8'hBF);
    rd(REG_BASE, q); chk("R9 ctrl only halt bit", q, 8'h20);
  endtask

  task automatic t_power();
    logic [7:0] q;
    wr(10'h123, 8'h22);
    @(negedge clk); pwr_ok = 0;
    wr(10'h123, 8'h44);
    wr(REG_BASE, 8'h40);
    @(negedge clk); addr = 10'h123; ce_n = 0; oe_n = 0; #1;
    chk("R10 no drive unpowered", data_io, 8'hzz);
    ce_n = 1; oe_n = 1;
    @(negedge clk); pwr_ok = 1;
    rd(10'h123, q); chk("R10 ram kept", q, 8'h22);
    live = 64'h25_02_02_04_01_02_03_20;
    pulse_tick();
    check_all("R10 halt not set", 1'b0, live);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ram();
    t_tick();
    t_halt();
    t_ignored();
    t_power();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule